// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Generator

This block is a register-programmed pulse-width generator with one or two output channels. A single shared control word holds a ten-bit field for every channel, and each channel also has its own word that holds a period count and a duty count. Each channel divides the block clock by a ratio picked from a coded table. The divided ticks step a period counter, and the output is asserted while that counter is below the duty count.

Software programs a channel by writing its period/duty word and then setting the clock-gate and enable bits in its control field. A new period/duty value written while the channel runs is held pending. A per-channel ready flag shows it is pending. The value is taken over only when the running period ends, so no period is cut short. A channel can also pass the block clock straight to its pin, and it can divide by one.

Top module: `prescaled_pwm`

## Requirements
- R1: The control word is at byte address 0x0. Channel n's ten-bit field starts at bit 15*n and holds: [3:0] divider code, bit 4 enable, bit 5 active level, bit 6 clock gate, bit 7 mode, bit 8 pulse, bit 9 direct. All ten bits read back as written. Channel n's period/duty word is at 0x4+4*n, with the duty count in [15:0] and the stored period in [31:16]. It reads back as written. Bits 28+n of the control word are read-only.
- R2: Divider codes 0,1,2,3,4 divide by 120,180,240,360,480. Codes 8,9,10,11,12 divide by 12000,24000,36000,48000,72000. Code 15 divides by one. With a ratio N, the period counter advances once every N clocks.
- R3: A running channel's period lasts (stored period + 1) ticks. The output is asserted while the tick count, which starts at 0 when the channel starts running, is below the duty count.
- R4: A set active-level bit drives the pin high when asserted and low otherwise. A clear bit inverts the pin.
- R5: A duty count of 0 keeps the output deasserted for the whole period. A duty count of at least the period length (stored period + 1) keeps it asserted.
- R6: A channel runs only while both its clock-gate and enable bits are 1. Otherwise its divider and counter are held at zero and its pin sits at the inactive level (low if the active-level bit is 1, high if it is 0). The reset state is therefore a high pin.
- R7: The reserved divider codes 5, 6, 7, 13 and 14 stop the channel's ticks. The counter and the pin then hold their values.
- R8: When a channel's direct bit is 1, its pin carries the block clock itself, whatever the enable, gate and other bits hold.
- R9: Writing a period/duty word sets ready bit 28+n. If the channel is not running, the value is loaded on the next clock and the bit clears. If it is running, the value is loaded, and the bit cleared, only at the clock where the current period ends.
- R10: A divider code written while the clock gate is 0 is used from the next gate-on, with the divider and counter starting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider source |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address of the word accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| pwmOut | output | NUM_CH | Channel pins |

## Verification
The case that needs care is a software update that lands in the same clock as the period-end load. A running channel then has a new period/duty word written while its counter is partway through an old period. The bench places the write a known number of ticks before the boundary. It reads the ready bit on each cycle up to that boundary, and it checks that the pin keeps the old period's shape until the wrap and takes the new shape afterwards. A second race pits a control write that selects a reserved code against a tick already due from the old code: the bench expects that last tick to land and the counter then to freeze.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;
  localparam int FIELD_STRIDE = 15;
  localparam int FIELD_W      = 10;
  localparam int READY_BASE   = 28;
  localparam int CNT_W        = 16;
  localparam int RATIO_W      = 17;

  // Per-channel control field, MSB first so that it matches bits [9:0]
  typedef struct packed {
    logic       direct;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       actHigh;
    logic       en;
    logic [3:0] code;
  } chanField_t;

  // Strobes from control to datapath for one channel
  typedef struct packed {
    logic             direct;
    logic             gate;
    logic             actHigh;
    logic             en;
    logic [3:0]       code;
    logic             pend;
    logic [CNT_W-1:0] prdNew;
    logic [CNT_W-1:0] dutyNew;
  } chanCmd_t;

  // Divide ratio for a code; zero marks a code that yields no ticks
  function automatic logic [RATIO_W-1:0] divRatio(input logic [3:0] code, input logic div1Ok);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd0:    r = 17'd120;
      4'd1:    r = 17'd180;
      4'd2:    r = 17'd240;
      4'd3:    r = 17'd360;
      4'd4:    r = 17'd480;
      4'd8:    r = 17'd12000;
      4'd9:    r = 17'd24000;
      4'd10:   r = 17'd36000;
      4'd11:   r = 17'd48000;
      4'd12:   r = 17'd72000;
      4'd15:   r = div1Ok ? 17'd1 : 17'd0;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ppwm_regs.sv
module ppwm_regs
  import ppwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wrData,
  output logic [31:0]             rdData,
  input  logic [NUM_CH-1:0]       loadDone,
  output chanCmd_t [NUM_CH-1:0]   cmd
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              ctrlHit;
  chanField_t        fieldQ  [NUM_CH];
  logic [31:0]       shadowQ [NUM_CH];
  logic              readyQ  [NUM_CH];

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign ctrlHit = wrEn & aligned & (wordIdx == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic prdHit;
    assign prdHit = wrEn & aligned & (wordIdx == WORD_W'(ch + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fieldQ[ch]  <= '0;
        shadowQ[ch] <= '0;
        readyQ[ch]  <= 1'b0;
      end else begin
        if (ctrlHit) fieldQ[ch] <= chanField_t'(wrData[ch*FIELD_STRIDE +: FIELD_W]);
        if (prdHit) begin
          shadowQ[ch] <= wrData;
          readyQ[ch]  <= 1'b1;
        end else if (loadDone[ch]) begin
          readyQ[ch]  <= 1'b0;
        end
      end
    end

    assign cmd[ch] = '{direct:  fieldQ[ch].direct,
                       gate:    fieldQ[ch].gate,
                       actHigh: fieldQ[ch].actHigh,
                       en:      fieldQ[ch].en,
                       code:    fieldQ[ch].code,
                       pend:    readyQ[ch],
                       prdNew:  shadowQ[ch][31:16],
                       dutyNew: shadowQ[ch][15:0]};
  end

  always_comb begin
    rdData = '0;
    if (aligned) begin
      if (wordIdx == '0) begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
          rdData[ch*FIELD_STRIDE +: FIELD_W] = fieldQ[ch];
          rdData[READY_BASE + ch]            = readyQ[ch];
        end
      end else begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
          if (wordIdx == WORD_W'(ch + 1)) rdData = shadowQ[ch];
        end
      end
    end
  end
endmodule

// File: rtl/ppwm_datapath.sv
module ppwm_datapath
  import ppwm_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter bit HAS_DIV1   = 1'b1,
  parameter bit HAS_DIRECT = 1'b1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  chanCmd_t [NUM_CH-1:0]             cmd,
  output logic [NUM_CH-1:0]                 loadDone,
  output logic [NUM_CH-1:0]                 pwmOut,
  output logic [NUM_CH-1:0][CNT_W-1:0]      cntMon,
  output logic [NUM_CH-1:0][CNT_W-1:0]      prdMon,
  output logic [NUM_CH-1:0][CNT_W-1:0]      dutyMon,
  output logic [NUM_CH-1:0]                 runMon,
  output logic [NUM_CH-1:0]                 haltMon,
  output logic [NUM_CH-1:0]                 directMon
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] pscQ;
    logic [CNT_W-1:0]   cntQ;
    logic [CNT_W-1:0]   prdQ;
    logic [CNT_W-1:0]   dutyQ;
    logic               run;
    logic               tick;
    logic               wrap;
    logic               asrt;
    logic               level;

    assign ratio = divRatio(cmd[ch].code, HAS_DIV1);
    assign run   = cmd[ch].gate & cmd[ch].en;
    assign tick  = run & (ratio != '0) & (pscQ == ratio - 1'b1);
    assign wrap  = tick & (cntQ == prdQ);
    assign loadDone[ch] = cmd[ch].pend & (~run | wrap);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pscQ  <= '0;
        cntQ  <= '0;
        prdQ  <= '0;
        dutyQ <= '0;
      end else begin
        if (!run) begin
          pscQ <= '0;
          cntQ <= '0;
        end else if (tick) begin
          pscQ <= '0;
          cntQ <= wrap ? '0 : cntQ + 1'b1;
        end else if (ratio != '0) begin
          pscQ <= pscQ + 1'b1;
        end
        if (loadDone[ch]) begin
          prdQ  <= cmd[ch].prdNew;
          dutyQ <= cmd[ch].dutyNew;
        end
      end
    end

    assign asrt  = run & (cntQ < dutyQ);
    assign level = cmd[ch].actHigh ? asrt : ~asrt;
    assign directMon[ch] = HAS_DIRECT & cmd[ch].direct;
    assign pwmOut[ch]    = directMon[ch] ? clk : level;

    assign cntMon[ch]  = cntQ;
    assign prdMon[ch]  = prdQ;
    assign dutyMon[ch] = dutyQ;
    assign runMon[ch]  = run;
    assign haltMon[ch] = run & (ratio == '0);
  end
endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
  import ppwm_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 4,
  parameter bit HAS_DIV1   = 1'b1,
  parameter bit HAS_DIRECT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCmd_t [NUM_CH-1:0]          cmd;
  logic [NUM_CH-1:0]              loadDone;
  logic [NUM_CH-1:0][CNT_W-1:0]   cntMon;
  logic [NUM_CH-1:0][CNT_W-1:0]   prdMon;
  logic [NUM_CH-1:0][CNT_W-1:0]   dutyMon;
  logic [NUM_CH-1:0]              runMon;
  logic [NUM_CH-1:0]              haltMon;
  logic [NUM_CH-1:0]              directMon;

  ppwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .loadDone(loadDone), .cmd(cmd)
  );

  ppwm_datapath #(.NUM_CH(NUM_CH), .HAS_DIV1(HAS_DIV1), .HAS_DIRECT(HAS_DIRECT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadDone(loadDone), .pwmOut(pwmOut),
    .cntMon(cntMon), .prdMon(prdMon), .dutyMon(dutyMon),
    .runMon(runMon), .haltMon(haltMon), .directMon(directMon)
  );
endmodule

// File: rtl/ppwm_checker.sv
module ppwm_checker
  import ppwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [ADDR_W-1:0]             addr,
  input logic [NUM_CH-1:0]             pwmOut,
  input chanCmd_t [NUM_CH-1:0]         cmd,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cntMon,
  input logic [NUM_CH-1:0][CNT_W-1:0]  prdMon,
  input logic [NUM_CH-1:0][CNT_W-1:0]  dutyMon,
  input logic [NUM_CH-1:0]             runMon,
  input logic [NUM_CH-1:0]             haltMon,
  input logic [NUM_CH-1:0]             directMon
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R3: the tick count never passes the loaded period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
      cntMon[i] <= prdMon[i]);

    // R5: zero duty keeps the pin deasserted
    a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
      (runMon[i] && dutyMon[i] == '0 && !directMon[i]) |-> (pwmOut[i] == !cmd[i].actHigh));

    // R6: a stopped channel sits at its inactive level
    a_r6_stopped_inactive: assert property (@(posedge clk) disable iff (!rstN)
      (!runMon[i] && !directMon[i]) |-> (pwmOut[i] == !cmd[i].actHigh));

    // R7: a reserved code freezes the counter while control is untouched
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
      (haltMon[i] && !(wrEn && addr == '0)) |=> $stable(cntMon[i]));

    // R9: a period/duty write raises the pending flag
    a_r9_ready_set: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(4 * (i + 1))) |=> cmd[i].pend);
  end
endmodule

bind prescaled_pwm ppwm_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .pwmOut(pwmOut), .cmd(cmd),
  .cntMon(cntMon), .prdMon(prdMon), .dutyMon(dutyMon),
  .runMon(runMon), .haltMon(haltMon), .directMon(directMon)
);

// File: tb/sim_prescaled_pwm.sv
`timescale 1ns/1ps
module sim_prescaled_pwm;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [NUM_CH-1:0] pwmOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  prescaled_pwm #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut)
  );

  typedef struct packed {
    logic [0:0]  ch;
    logic [15:0] prd;
    logic [15:0] duty;
    logic        act;
  } vec_t;

  // channel, stored period, duty, active level
  localparam vec_t VECS [8] = '{
    '{1'b0, 16'd3, 16'd1, 1'b1},
    '{1'b0, 16'd3, 16'd2, 1'b0},
    '{1'b0, 16'd0, 16'd1, 1'b1},
    '{1'b0, 16'd4, 16'd0, 1'b1},
    '{1'b0, 16'd2, 16'd5, 1'b1},
    '{1'b1, 16'd2, 16'd1, 1'b1},
    '{1'b1, 16'd5, 16'd3, 1'b0},
    '{1'b1, 16'd2, 16'd3, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after capture
  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic [31:0] fld(input int ch, input logic [3:0] code, input logic en,
                                      input logic act, input logic gate, input logic dir);
    logic [31:0] f;
    f = {22'd0, dir, 1'b0, 1'b0, gate, act, en, code};
    return f << (15 * ch);
  endfunction

  task automatic runDivided(input logic [3:0] code, input int ratio, input string tag);
    regWrite(4'h0, fld(0, code, 1'b1, 1'b1, 1'b0, 1'b0));  // code set while gated off
    regWrite(4'h0, fld(0, code, 1'b1, 1'b1, 1'b1, 1'b0));  // now k = 0
    for (int k = 0; k <= 2 * ratio; k++) begin
      #1;
      if (k == ratio - 1)     chk(tag, {31'd0, pwmOut[0]}, 32'd1);
      if (k == ratio)         chk(tag, {31'd0, pwmOut[0]}, 32'd0);
      if (k == 2 * ratio - 1) chk(tag, {31'd0, pwmOut[0]}, 32'd0);
      if (k == 2 * ratio)     chk(tag, {31'd0, pwmOut[0]}, 32'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] wv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R6: inverted inactive level is high; R1: registers clear)
    #1 chk("R6 reset pins", {30'd0, pwmOut}, 32'd3);
    regRead(4'h0, rv); chk("R1 reset ctrl", rv, 32'd0);
    regRead(4'h4, rv); chk("R1 reset word0", rv, 32'd0);
    regRead(4'h8, rv); chk("R1 reset word1", rv, 32'd0);
    @(negedge clk);

    // R1 readback, ready bits not writable
    wv = 32'hF000_0000 | (32'h1C5 << 15) | 32'h0C5;
    regWrite(4'h0, wv);
    regRead(4'h0, rv); chk("R1 ctrl readback", rv, (32'h1C5 << 15) | 32'h0C5);
    @(negedge clk);
    regWrite(4'h8, 32'hABCD_1234);
    regRead(4'h8, rv); chk("R1 word1 readback", rv, 32'hABCD_1234);
    regRead(4'h0, rv); chk("R9 idle ready set", {30'd0, rv[29:28]}, 32'd2);
    @(negedge clk);
    regRead(4'h0, rv); chk("R9 idle ready clear", {30'd0, rv[29:28]}, 32'd0);
    @(negedge clk);

    // Table walk: R3 period/duty, R4 polarity, R5 duty extremes, R1 channel offsets
    for (int v = 0; v < 8; v++) begin
      vec_t t;
      t = VECS[v];
      regWrite(4'h0, 32'd0);
      regWrite(ADDR_W'(4 + 4 * int'(t.ch)), {t.prd, t.duty});
      regWrite(4'h0, fld(int'(t.ch), 4'd15, 1'b1, t.act, 1'b1, 1'b0));
      for (int k = 0; k < 2 * (int'(t.prd) + 1) + 2; k++) begin
        int  kk;
        logic ex;
        kk = k % (int'(t.prd) + 1);
        ex = (kk < int'(t.duty)) ? t.act : !t.act;
        #1 chk("R3 R4 R5 waveform", {31'd0, pwmOut[t.ch]}, {31'd0, ex});
        @(negedge clk);
      end
    end

    // R6 gate or enable clear
    regWrite(4'h0, fld(0, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0));
    @(negedge clk); #1 chk("R6 gate off act high", {31'd0, pwmOut[0]}, 32'd0);
    @(negedge clk);
    regWrite(4'h0, fld(0, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk); #1 chk("R6 gate off act low", {31'd0, pwmOut[0]}, 32'd1);
    @(negedge clk);
    regWrite(4'h0, fld(0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0));
    @(negedge clk); #1 chk("R6 enable off", {31'd0, pwmOut[0]}, 32'd0);
    @(negedge clk);

    // R9 update while running waits for period end
    regWrite(4'h0, 32'd0);
    regWrite(4'h4, {16'd3, 16'd1});
    regWrite(4'h0, fld(0, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0));  // k=0
    @(negedge clk);                                          // k=1
    regWrite(4'h4, {16'd1, 16'd1});                          // k=2
    regRead(4'h0, rv); chk("R9 pending k2", {31'd0, rv[28]}, 32'd1);
    chk("R9 old period k2", {31'd0, pwmOut[0]}, 32'd0);
    @(negedge clk);                                          // k=3
    regRead(4'h0, rv); chk("R9 pending k3", {31'd0, rv[28]}, 32'd1);
    chk("R9 old period k3", {31'd0, pwmOut[0]}, 32'd0);
    @(negedge clk);                                          // k=4
    regRead(4'h0, rv); chk("R9 loaded k4", {31'd0, rv[28]}, 32'd0);
    chk("R9 new period k4", {31'd0, pwmOut[0]}, 32'd1);
    @(negedge clk);                                          // k=5
    #1 chk("R9 new period k5", {31'd0, pwmOut[0]}, 32'd0);
    @(negedge clk);                                          // k=6
    #1 chk("R9 new period k6", {31'd0, pwmOut[0]}, 32'd1);
    @(negedge clk);

    // R7 reserved code freezes the counter
    regWrite(4'h0, 32'd0);
    regWrite(4'h4, {16'd1, 16'd1});
    regWrite(4'h0, fld(0, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0));  // k=0
    #1 chk("R7 before freeze", {31'd0, pwmOut[0]}, 32'd1);
    regWrite(4'h0, fld(0, 4'd13, 1'b1, 1'b1, 1'b1, 1'b0));  // k=1, last tick landed
    for (int k = 1; k < 7; k++) begin
      #1 chk("R7 frozen", {31'd0, pwmOut[0]}, 32'd0);
      @(negedge clk);
    end

    // R2 divider ratios, R10 code change while gated off
    regWrite(4'h0, 32'd0);
    regWrite(4'h4, {16'd1, 16'd1});
    runDivided(4'd0, 120, "R2 R10 code0");
    runDivided(4'd3, 360, "R2 R10 code3");
    runDivided(4'd8, 12000, "R2 R10 code8");
    runDivided(4'd10, 36000, "R2 R10 code10");

    // R8 direct clock on channel 1 overrides enable and gate
    regWrite(4'h0, fld(1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b1) | fld(0, 4'd15, 1'b0, 1'b1, 1'b0, 1'b0));
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5 chk("R8 clock high", {31'd0, pwmOut[1]}, 32'd1);
      @(negedge clk); #5 chk("R8 clock low", {31'd0, pwmOut[1]}, 32'd0);
      chk("R8 other channel idle", {31'd0, pwmOut[0]}, 32'd0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule